// File: doc/BRIEF.md
# Pipelined Burst Static RAM Model

This block is a synthesizable model of a synchronous burst static RAM with a registered read path. The array is small, by default 256 words of four byte lanes. Every control input is sampled on the rising clock edge. These inputs are three chip enables, two address strobes (a processor strobe and a controller strobe), a burst advance, a global write, a byte-write enable and one write select per lane. Write data comes in on a separate input port. Instead of a tristate bus, the model has a data output and a drive flag. The flag is high only when the model would be driving the pins.

An access starts when a strobe loads an address. The address is then held in a register, and its two lowest bits seed a two-bit burst counter. Each advance cycle steps the counter, in linear or interleaved order according to a static mode input. Read data passes through the array's read register and then through an output register. The output enable gates the drive flag without reference to the clock. The drive flag also stays low for the first output cycle of a read that starts from the deselected state.

Top module: `sbsram_core`

## Requirements
- R1: A rising edge with `rst_n` low leaves the model deselected with `rdata_drive` low and `rdata` zero.
- R2: A strobe that is acted on loads `addr` when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If any enable is inactive, the strobe deselects the model instead.
- R3: If both strobes are low in the same cycle, only the processor strobe is acted on. A processor-strobe load is always a read, and the write controls are ignored in that cycle.
- R4: With `ce1_n` high, the processor strobe has no effect. The controller strobe or the advance input decides what that cycle does.
- R5: On a write-capable cycle (a controller-strobe load or an advance), `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` hold.
- R6: With `gw_n`=1 and `bwe_n`=0, lane i (bits 8i+7:8i) is written only when `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1, the access is a read.
- R7: For a read access at edge k, the data and the drive flag show that word after edge k+1 (subject to R10 and R11).
- R8: An advance cycle (`adv_n`=0 with no strobe acted on while selected) accesses the loaded upper address bits with burst offset n. The offset is (start+n) mod 4 when `burst_mode`=0 and start XOR n when `burst_mode`=1, where n counts advances since the load.
- R9: A cycle with no strobe acted on, and either `adv_n` high or the model deselected, performs no access, and the output register keeps its value.
- R10: For a read loaded while deselected, `rdata_drive` stays low for its first output cycle even with `oe_n` low. On a following hold cycle the word is driven.
- R11: While `oe_n` is high, `rdata_drive` is low and `rdata` is zero. This takes effect at once, with no clock edge.
- R12: After a write access or a deselect at edge k, `rdata_drive` is low after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address taken by a strobe |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| burst_mode | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | High when the model drives read data |

## Verification
The output pair changes one edge after the edge that performs a read, because the array read register and the output register sit in series. A write or a deselect clears the drive flag one edge later in the same way, and the output-enable gating takes effect within the same cycle. The bench applies inputs on the falling edge. Its reference model steps at each rising edge through the same two-stage output timing, and it compares `rdata` and `rdata_drive` on the next falling edge. For the output-enable cases it also toggles `oe_n` in the middle of a cycle and compares again one time unit later.

// File: rtl/sbsram_pkg.sv
// Shared types and helpers for the burst static RAM model.
// Assumes a fixed two-bit burst counter as used by four-beat bursts.
package sbsram_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_ADV   = 2'd2,
        CMD_DESEL = 2'd3
    } cmd_e;

    // Burst offset for a given start value and beat count.
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic               interleave,
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction
endpackage

// File: rtl/sbsram_cmd.sv
// Command decode: qualifies the two address strobes with the chip
// enables, applies processor-strobe priority, and decodes write lanes.
// Assumes all inputs are already sampled values for the current cycle.
module sbsram_cmd
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             desel_q,
    output cmd_e             cmd,
    output logic             wr_req,
    output logic             rd_req,
    output logic [LANES-1:0] lane_we
);
    logic chip_ok;
    logic proc_hit;
    logic ctrl_hit;
    logic want_wr;
    logic access;

    // Strobe priority and chip-select qualification.
    always_comb begin
        chip_ok  = !ce1_n && ce2 && !ce3_n;
        proc_hit = !adsp_n && !ce1_n;
        ctrl_hit = !proc_hit && !adsc_n;
        if (proc_hit || ctrl_hit) begin
            cmd = chip_ok ? CMD_LOAD : CMD_DESEL;
        end else if (!adv_n && !desel_q) begin
            cmd = CMD_ADV;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // Read/write split and lane enable decode.
    always_comb begin
        want_wr = !gw_n || !bwe_n;
        access  = (cmd == CMD_LOAD) || (cmd == CMD_ADV);
        wr_req  = access && want_wr && !proc_hit;
        rd_req  = access && !wr_req;
        if (!gw_n) begin
            lane_we = '1;
        end else if (!bwe_n) begin
            lane_we = ~bw_n;
        end else begin
            lane_we = '0;
        end
    end
endmodule

// File: rtl/sbsram_addr.sv
// Address register and two-bit burst counter. Gives the access address
// for the current cycle: the input address on a load, else the next
// burst address from the held base. Assumes burst_mode is static.
module sbsram_addr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              burst_mode,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int HI_W = ADDR_W - BURST_W;
    localparam logic [BURST_W-1:0] BEAT_ONE = BURST_W'(1);

    logic [HI_W-1:0]    base_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] beat_nxt;

    // Access address for the current cycle.
    always_comb begin
        beat_nxt = beat_q + BEAT_ONE;
        if (cmd == CMD_LOAD) begin
            acc_addr = addr_in;
        end else begin
            acc_addr = {base_q, burst_offset(burst_mode, start_q, beat_nxt)};
        end
    end

    // Base, start and beat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (cmd == CMD_LOAD) begin
            base_q  <= addr_in[ADDR_W-1:BURST_W];
            start_q <= addr_in[BURST_W-1:0];
            beat_q  <= '0;
        end else if (cmd == CMD_ADV) begin
            beat_q  <= beat_nxt;
        end
    end
endmodule

// File: rtl/sbsram_array.sv
// Byte-lane storage array with a registered read port. One memory per
// lane; the read register only updates on read cycles. Contents are
// not reset.
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write and registered lane read.
        always_ff @(posedge clk) begin
            if (we && lane_we[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (re) begin
                rdata[g*LANE_W +: LANE_W] <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/sbsram_core.sv
// Top of the burst static RAM model. Decodes commands, tracks the
// deselected state, runs the two-stage read pipeline (array register
// then output register), and gates drive with output enable and the
// first-read mask. Assumes synchronous inputs are stable around the edge.
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int DATA_W = LANES * LANE_W;

    cmd_e              cmd;
    logic              wr_req;
    logic              rd_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] arr_rdata;
    logic              desel_q;
    logic              rd_v_q;
    logic              first_q;
    logic              dout_v_q;
    logic              mask_q;
    logic [DATA_W-1:0] dout_q;

    sbsram_cmd #(.LANES(LANES)) u_cmd (
        .ce1_n   (ce1_n),
        .ce2     (ce2),
        .ce3_n   (ce3_n),
        .adsp_n  (adsp_n),
        .adsc_n  (adsc_n),
        .adv_n   (adv_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .desel_q (desel_q),
        .cmd     (cmd),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .lane_we (lane_we)
    );

    sbsram_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .addr_in    (addr),
        .burst_mode (burst_mode),
        .acc_addr   (acc_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (wr_req),
        .re      (rd_req),
        .lane_we (lane_we),
        .addr    (acc_addr),
        .wdata   (wdata),
        .rdata   (arr_rdata)
    );

    // Deselected-state flag: set by a deselect, cleared by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desel_q <= 1'b1;
        end else if (cmd == CMD_DESEL) begin
            desel_q <= 1'b1;
        end else if (cmd == CMD_LOAD) begin
            desel_q <= 1'b0;
        end
    end

    // Stage one: read-valid and first-read-after-deselect markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q  <= 1'b0;
            first_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_LOAD, CMD_ADV: begin
                    rd_v_q  <= rd_req;
                    first_q <= rd_req && desel_q;
                end
                CMD_DESEL: begin
                    rd_v_q  <= 1'b0;
                    first_q <= 1'b0;
                end
                default: begin
                    first_q <= 1'b0;
                end
            endcase
        end
    end

    // Stage two: output register, valid and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_v_q <= 1'b0;
            mask_q   <= 1'b0;
            dout_q   <= '0;
        end else begin
            dout_v_q <= rd_v_q;
            mask_q   <= first_q;
            if (rd_v_q) begin
                dout_q <= arr_rdata;
            end
        end
    end

    // Asynchronous output-enable gating of the drive flag and data.
    always_comb begin
        rdata_drive = !oe_n && dout_v_q && !mask_q;
        rdata       = rdata_drive ? dout_q : '0;
    end
endmodule

// File: rtl/sbsram_chk.sv
// Protocol checker for sbsram_core, attached with bind below. Relates
// strobe and enable inputs to the drive flag and output registers.
module sbsram_chk
    import sbsram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic              rdata_drive,
    input logic              desel_q,
    input cmd_e              cmd,
    input logic              rd_req,
    input logic [DATA_W-1:0] dout_q,
    input logic              dout_v_q
);
    logic chip_ok;
    logic proc_seen;
    logic any_seen;

    assign chip_ok   = !ce1_n && ce2 && !ce3_n;
    assign proc_seen = !adsp_n && !ce1_n;
    assign any_seen  = proc_seen || !adsc_n;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_drive); // R11

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_seen && !adsc_n && chip_ok && !gw_n) |=> ##1 !rdata_drive); // R12

    AST_DESEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_seen && !chip_ok) |=> ##1 !rdata_drive); // R2

    AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_q && cmd == CMD_LOAD && rd_req) |=> ##1 !rdata_drive); // R10

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_seen && (adv_n || desel_q)) |=> ##1 ($stable(dout_q) && $stable(dout_v_q))); // R9
endmodule

bind sbsram_core sbsram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .adsp_n      (adsp_n),
    .adsc_n      (adsc_n),
    .adv_n       (adv_n),
    .gw_n        (gw_n),
    .oe_n        (oe_n),
    .rdata_drive (rdata_drive),
    .desel_q     (desel_q),
    .cmd         (cmd),
    .rd_req      (rd_req),
    .dout_q      (dout_q),
    .dout_v_q    (dout_v_q)
);

// File: tb/tb_sbsram_core.sv
// Self-checking bench for sbsram_core: directed corner cases plus seeded
// random traffic, compared each cycle against a requirement-level model.
module tb_sbsram_core;
    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n;
    logic              gw_n, bwe_n, burst_mode, oe_n;
    logic [LANES-1:0]  bw_n;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rdata_drive;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic              m_desel;
    logic [ADDR_W-3:0] m_base;
    logic [1:0]        m_start, m_beat;
    logic              s1_v, s1_first;
    logic [DATA_W-1:0] s1_data;
    logic              o_v, o_mask;
    logic [DATA_W-1:0] o_data;

    sbsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_mode(burst_mode),
        .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    always #4 clk = ~clk;

    function automatic logic [1:0] beat_off(input logic il, input logic [1:0] s, input logic [1:0] n);
        return il ? (s ^ n) : (s + n);
    endfunction

    // Model one rising edge from the currently applied inputs.
    task automatic model_edge();
        logic sel, ps, cs, wr, acc, was_desel;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] a;
        if (!rst_n) begin
            m_desel = 1'b1; m_base = '0; m_start = '0; m_beat = '0;
            s1_v = 1'b0; s1_first = 1'b0; o_v = 1'b0; o_mask = 1'b0; o_data = '0;
            return;
        end
        sel = !ce1_n && ce2 && !ce3_n;
        ps  = !adsp_n && !ce1_n;
        cs  = !ps && !adsc_n;
        wr  = (!gw_n || !bwe_n) && !ps;
        lanes = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
        o_v = s1_v; o_mask = s1_first;
        if (s1_v) o_data = s1_data;
        acc = 1'b0; was_desel = 1'b0; a = '0;
        if (ps || cs) begin
            if (sel) begin
                a = addr; m_base = addr[ADDR_W-1:2]; m_start = addr[1:0]; m_beat = '0;
                acc = 1'b1; was_desel = m_desel; m_desel = 1'b0;
            end else begin
                m_desel = 1'b1; s1_v = 1'b0; s1_first = 1'b0;
            end
        end else if (!adv_n && !m_desel) begin
            m_beat = m_beat + 2'd1;
            a = {m_base, beat_off(burst_mode, m_start, m_beat)};
            acc = 1'b1;
        end else begin
            s1_first = 1'b0;
        end
        if (acc) begin
            if (wr) begin
                for (int i = 0; i < LANES; i++)
                    if (lanes[i]) m_mem[a][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                s1_v = 1'b0; s1_first = 1'b0;
            end else begin
                s1_v = 1'b1; s1_data = m_mem[a]; s1_first = was_desel;
            end
        end
    endtask

    task automatic check(input string tag);
        logic              e_drv;
        logic [DATA_W-1:0] e_dat;
        e_drv = !oe_n && o_v && !o_mask;
        e_dat = e_drv ? o_data : '0;
        checks++;
        if (rdata_drive !== e_drv) begin
            fails++;
            $display("FAIL %s drive: got %0b expected %0b", tag, rdata_drive, e_drv);
        end
        checks++;
        if (rdata !== e_dat) begin
            fails++;
            $display("FAIL %s data: got %h expected %h", tag, rdata, e_dat);
        end
    endtask

    // Apply current inputs across one rising edge, then compare.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
        bw_n = '1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; oe_n = 1'b0;
    endtask

    task automatic ctrl_load(input logic [ADDR_W-1:0] a, input string tag);
        idle(); adsc_n = 1'b0; addr = a; step(tag);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; idle(); addr = '0; wdata = '0; burst_mode = 1'b0;
        // R1: reset with a read request pending stays undriven
        adsc_n = 1'b0;
        step("R1"); step("R1"); step("R1");
        rst_n = 1'b1; idle();
        step("R1");

        // R5: fill every word with a global write via the controller strobe
        for (int i = 0; i < DEPTH; i++) begin
            idle(); adsc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1111;
            addr = ADDR_W'(i); wdata = $urandom; step("R5");
        end
        idle(); step("R5");

        // R7: read latency after a selected load, then hold
        ctrl_load(8'd5, "R7"); idle(); step("R7"); step("R9");

        // R10: deselect, masked first read, then driven on hold
        idle(); adsc_n = 1'b0; ce2 = 1'b0; step("R2"); idle(); step("R12");
        ctrl_load(8'd9, "R10"); idle(); step("R10"); step("R10");

        // R9: advance while deselected is ignored
        idle(); adsc_n = 1'b0; ce3_n = 1'b1; step("R2");
        idle(); adv_n = 1'b0; step("R9"); step("R9");

        // R3: both strobes with write controls -> processor read only
        idle(); adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 8'd10;
        wdata = 32'hDEAD_BEEF; step("R3");
        idle(); step("R3"); step("R3");
        ctrl_load(8'd10, "R3"); idle(); step("R3");

        // R4: processor strobe ignored with ce1_n high; advance acts
        ctrl_load(8'd20, "R4"); idle(); step("R4");
        idle(); adsp_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; step("R4");
        idle(); step("R4");

        // R6: byte write of lanes 0 and 2, then read back; read with bwe_n high
        idle(); adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010; addr = 8'd33;
        wdata = 32'h1122_3344; step("R6"); idle(); step("R12");
        ctrl_load(8'd33, "R6"); idle(); bw_n = 4'b0000; step("R6"); step("R6");

        // R8: linear and interleaved bursts from start offset 2
        for (int m = 0; m < 2; m++) begin
            burst_mode = m[0];
            ctrl_load(8'd62, "R8");
            for (int b = 0; b < 4; b++) begin
                idle(); adv_n = 1'b0; step("R8");
            end
            idle(); step("R8");
        end
        burst_mode = 1'b0;

        // R11: output enable removes drive within the cycle
        ctrl_load(8'd77, "R11"); idle(); step("R11");
        #1 oe_n = 1'b1; #1 check("R11");
        oe_n = 1'b0; #1 check("R11");
        @(negedge clk);

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            if (c % 200 == 0) burst_mode = $urandom % 2;
            ce1_n  = ($urandom % 8) == 0;
            ce2    = ($urandom % 8) != 0;
            ce3_n  = ($urandom % 8) == 0;
            adsp_n = ($urandom % 4) != 0;
            adsc_n = ($urandom % 3) != 0;
            adv_n  = ($urandom % 2) != 0;
            gw_n   = ($urandom % 4) != 0;
            bwe_n  = ($urandom % 2) != 0;
            bw_n   = LANES'($urandom);
            oe_n   = ($urandom % 6) == 0;
            addr   = ADDR_W'($urandom);
            wdata  = $urandom;
            step("R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule